// File: doc/BRIEF.md
# Bidirectional Cascadable Row Driver Logic

This block is the logic core of a row driver with 64 outputs for a display panel. A serial shift register of 64 stages takes one bit per rising edge of the shift clock. A direction input sets which way the bits travel. The two serial pins swap roles with the direction. In forward mode pin A receives and pin B sends. In reverse mode pin B receives and pin A sends. The sending pin always presents the stage at the far end of the register, so several drivers can be chained to cover any number of rows. Each bidirectional pin is modelled as a separate input, output and output enable.

A level-sensitive latch sits behind the register and copies all of its bits while the strobe is high. The 64 driver outputs are taken from the latch and shaped by two controls. A blanking input forces every output to the level of the polarity input. Without blanking, the polarity input selects whether each output shows its latched bit as stored or inverted.

Top module: `row_drv_core`

## Requirements
- R1: An asynchronous active-low reset clears the shift register and the latch. With blank and polarity low, all driver outputs then read 0 and the active serial output reads 0.
- R2: With the direction input high (forward), each rising shift-clock edge loads stage Q1 from the pin A input and moves stage Qn into Qn+1. Driver output bit n-1 belongs to stage Qn, so Qn holds the bit presented n edges earlier.
- R3: In forward mode the pin B output shows stage Q64. The first bit presented therefore leaves on pin B after the 64th edge, and two chained drivers pass 128 bits end to end.
- R4: With the direction input low (reverse), each rising edge loads Q64 from the pin B input and moves Qn into Qn-1. The pin A output shows stage Q1, and two chained drivers pass 128 bits end to end in the opposite order.
- R5: The pin B output enable is high and the pin A output enable is low when the direction input is high. The two are swapped when it is low, so exactly one enable is high at any time.
- R6: With no rising shift-clock edge, the register holds its contents whatever the serial inputs do.
- R7: While the strobe is high, the latch follows the register. While the strobe is low, the latch holds its last value even when the register shifts.
- R8: While blank is high, every driver output equals the polarity input, whatever the latch and strobe hold.
- R9: While blank is low, driver output bit n-1 equals latch bit n XOR the polarity input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shift_clk | input | 1 | Shift clock; the register moves on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of register and latch |
| dir_fwd | input | 1 | 1 = forward (A in, B out), 0 = reverse (B in, A out) |
| ser_a_i | input | 1 | Pin A input side; serial data in forward mode |
| ser_a_o | output | 1 | Pin A output side; Q1 in reverse mode, 0 otherwise |
| ser_a_oe | output | 1 | Pin A output enable |
| ser_b_i | input | 1 | Pin B input side; serial data in reverse mode |
| ser_b_o | output | 1 | Pin B output side; Q64 in forward mode, 0 otherwise |
| ser_b_oe | output | 1 | Pin B output enable |
| strobe | input | 1 | High makes the latch transparent |
| blank | input | 1 | High forces all driver outputs to the polarity level |
| polarity | input | 1 | Blank level, or inversion of latched data |
| drv_o | output | 64 | Driver outputs, bit n-1 for stage Qn |

## Verification
The properties are sampled on the rising shift-clock edge. They assume that the direction, serial inputs, blank and polarity are stable across that edge. They also assume that any strobe pulse that should move the latch ends while the clock is low. The bench changes every input on the falling edge of a free-running reference clock. It pulses the strobe only while the shift clock is gated off, so each property sees a settled set of inputs. The shift clock is gated only while the reference clock is low, which keeps it free of glitches.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

  typedef enum logic {
    DIR_REV = 1'b0,
    DIR_FWD = 1'b1
  } shift_dir_e;

  // level driven on one output: blanked -> polarity, else data xor polarity
  function automatic logic drive_level(input logic blank_i, input logic pol_i,
                                       input logic bit_i);
    return blank_i ? pol_i : (bit_i ^ pol_i);
  endfunction

  // returns {pin A enable, pin B enable} for a direction
  function automatic logic [1:0] pin_enables(input shift_dir_e dir_i);
    return (dir_i == DIR_FWD) ? 2'b01 : 2'b10;
  endfunction

endpackage

// File: rtl/rdc_shift.sv
module rdc_shift #(
  parameter int STAGES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rdc_pkg::shift_dir_e dir_i,
  input  logic              din,
  output logic [STAGES-1:0] q,
  output logic              q_head,
  output logic              q_tail
);
  import rdc_pkg::*;

  localparam int LAST = STAGES - 1;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic from_lo;
    logic from_hi;
    if (i == 0) begin : g_first
      assign from_lo = din;
    end else begin : g_mid_lo
      assign from_lo = q[i-1];
    end
    if (i == LAST) begin : g_last
      assign from_hi = din;
    end else begin : g_mid_hi
      assign from_hi = q[i+1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= (dir_i == DIR_FWD) ? from_lo : from_hi;
    end
  end

  assign q_head = q[0];
  assign q_tail = q[LAST];

endmodule

// File: rtl/rdc_hold.sv
module rdc_hold #(
  parameter int STAGES = 64
) (
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [STAGES-1:0] d,
  output logic [STAGES-1:0] lat
);
  always_latch begin
    if (!rst_n)      lat <= '0;
    else if (strobe) lat <= d;
  end
endmodule

// File: rtl/rdc_shape.sv
module rdc_shape #(
  parameter int STAGES = 64
) (
  input  logic              blank,
  input  logic              polarity,
  input  logic [STAGES-1:0] lat,
  output logic [STAGES-1:0] drv
);
  import rdc_pkg::*;

  for (genvar i = 0; i < STAGES; i++) begin : g_out
    assign drv[i] = drive_level(blank, polarity, lat[i]);
  end
endmodule

// File: rtl/row_drv_core.sv
module row_drv_core #(
  parameter int STAGES = 64
) (
  input  logic              shift_clk,
  input  logic              rst_n,
  input  logic              dir_fwd,
  input  logic              ser_a_i,
  output logic              ser_a_o,
  output logic              ser_a_oe,
  input  logic              ser_b_i,
  output logic              ser_b_o,
  output logic              ser_b_oe,
  input  logic              strobe,
  input  logic              blank,
  input  logic              polarity,
  output logic [STAGES-1:0] drv_o
);
  import rdc_pkg::*;

  shift_dir_e        dir;
  logic              shift_in;
  logic [STAGES-1:0] reg_q;
  logic [STAGES-1:0] latch_q;
  logic              reg_head;
  logic              reg_tail;
  logic [1:0]        oe_pair;

  assign dir      = shift_dir_e'(dir_fwd);
  assign shift_in = (dir == DIR_FWD) ? ser_a_i : ser_b_i;
  assign oe_pair  = pin_enables(dir);
  assign ser_a_oe = oe_pair[1];
  assign ser_b_oe = oe_pair[0];
  assign ser_a_o  = oe_pair[1] & reg_head;
  assign ser_b_o  = oe_pair[0] & reg_tail;

  rdc_shift #(.STAGES(STAGES)) u_shift (
    .clk    (shift_clk),
    .rst_n  (rst_n),
    .dir_i  (dir),
    .din    (shift_in),
    .q      (reg_q),
    .q_head (reg_head),
    .q_tail (reg_tail)
  );

  rdc_hold #(.STAGES(STAGES)) u_hold (
    .rst_n  (rst_n),
    .strobe (strobe),
    .d      (reg_q),
    .lat    (latch_q)
  );

  rdc_shape #(.STAGES(STAGES)) u_shape (
    .blank    (blank),
    .polarity (polarity),
    .lat      (latch_q),
    .drv      (drv_o)
  );

endmodule

// File: rtl/rdc_chk.sv
module rdc_chk #(
  parameter int STAGES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dir_fwd,
  input logic              ser_a_i,
  input logic              ser_b_i,
  input logic              ser_a_o,
  input logic              ser_b_o,
  input logic              ser_a_oe,
  input logic              ser_b_oe,
  input logic              strobe,
  input logic              blank,
  input logic              polarity,
  input logic [STAGES-1:0] reg_q,
  input logic [STAGES-1:0] latch_q,
  input logic [STAGES-1:0] drv_o
);

  a_r2_fwd_shift: assert property (@(posedge clk) disable iff (!rst_n)
    dir_fwd |=> reg_q == {$past(reg_q[STAGES-2:0]), $past(ser_a_i)});

  a_r4_rev_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_fwd |=> reg_q == {$past(ser_b_i), $past(reg_q[STAGES-1:1])});

  a_r3_fwd_out: assert property (@(posedge clk) disable iff (!rst_n)
    dir_fwd |-> ser_b_o == reg_q[STAGES-1]);

  a_r4_rev_out: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_fwd |-> ser_a_o == reg_q[0]);

  a_r5_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ser_a_oe, ser_b_oe}) == 1 && ser_b_oe == dir_fwd);

  a_r7_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> latch_q == reg_q);

  a_r8_blank_level: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> drv_o == {STAGES{polarity}});

  a_r9_data_pol: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |-> drv_o == (latch_q ^ {STAGES{polarity}}));

endmodule

bind row_drv_core rdc_chk #(.STAGES(STAGES)) u_chk (
  .clk      (shift_clk),
  .rst_n    (rst_n),
  .dir_fwd  (dir_fwd),
  .ser_a_i  (ser_a_i),
  .ser_b_i  (ser_b_i),
  .ser_a_o  (ser_a_o),
  .ser_b_o  (ser_b_o),
  .ser_a_oe (ser_a_oe),
  .ser_b_oe (ser_b_oe),
  .strobe   (strobe),
  .blank    (blank),
  .polarity (polarity),
  .reg_q    (reg_q),
  .latch_q  (latch_q),
  .drv_o    (drv_o)
);

// File: tb/row_drv_core_bench.sv
module row_drv_core_bench;

  localparam int N = 64;

  logic clk = 1'b0;
  logic clk_en = 1'b0;
  logic rst_n = 1'b0;
  // inputs left floating read as 1
  logic dir_fwd = 1'b1;
  logic blank = 1'b1;
  logic polarity = 1'b1;
  logic strobe = 1'b0;
  logic head_in = 1'b0;
  logic tail_in = 1'b0;

  logic shift_clk;
  logic mid;
  logic a0_o, a0_oe, b0_o, b0_oe;
  logic a1_o, a1_oe, b1_o, b1_oe;
  logic [N-1:0] drv0, drv1;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;
  assign shift_clk = clk & clk_en;
  // shared wire between the two drivers, driven by whichever side is enabled
  assign mid = b0_oe ? b0_o : a1_o;

  row_drv_core #(.STAGES(N)) u_row_drv_core (
    .shift_clk(shift_clk), .rst_n(rst_n), .dir_fwd(dir_fwd),
    .ser_a_i(head_in), .ser_a_o(a0_o), .ser_a_oe(a0_oe),
    .ser_b_i(mid), .ser_b_o(b0_o), .ser_b_oe(b0_oe),
    .strobe(strobe), .blank(blank), .polarity(polarity), .drv_o(drv0));

  row_drv_core #(.STAGES(N)) u_row_drv_core_nx (
    .shift_clk(shift_clk), .rst_n(rst_n), .dir_fwd(dir_fwd),
    .ser_a_i(mid), .ser_a_o(a1_o), .ser_a_oe(a1_oe),
    .ser_b_i(tail_in), .ser_b_o(b1_o), .ser_b_oe(b1_oe),
    .strobe(strobe), .blank(blank), .polarity(polarity), .drv_o(drv1));

  function automatic logic pat(input int k, input int seed);
    return ((k * 13 + seed) % 7) < 3;
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic a_in, input logic b_in);
    @(negedge clk);
    head_in = a_in;
    tail_in = b_in;
    clk_en = 1'b1;
    @(posedge clk);
    #2;
  endtask

  task automatic latch_now();
    @(negedge clk);
    clk_en = 1'b0;
    strobe = 1'b1;
    #2;
    strobe = 1'b0;
    #1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] e0, e1;
    // R8 during reset with default-high controls
    #12;
    chk("R8 blank with default inputs", drv0, {N{1'b1}});
    blank = 1'b0;
    polarity = 1'b0;
    #1;
    chk("R1 reset drivers", drv0 | drv1, '0);
    chk("R1 reset serial out", {63'd0, b1_o}, '0);
    chk("R5 forward enables", {60'd0, a0_oe, b0_oe, a1_oe, b1_oe}, 64'b0101);
    @(negedge clk);
    rst_n = 1'b1;

    // forward fill of 128 bits through the chain (R2, R3)
    for (int k = 0; k < 2 * N; k++) step(pat(k, 1), 1'b0);
    chk("R3 first bit on tail after 128 edges", {63'd0, b1_o}, {63'd0, pat(0, 1)});
    latch_now();
    for (int n = 1; n <= N; n++) begin
      e0[n-1] = pat(2 * N - n, 1);
      e1[n-1] = pat(N - n, 1);
    end
    chk("R2 forward stages first driver", drv0, e0);
    chk("R2 forward stages second driver", drv1, e1);
    for (int m = 0; m < 2 * N - 1; m++) begin
      step(1'b0, 1'b0);
      chk("R3 forward serial stream", {63'd0, b1_o}, {63'd0, pat(m + 1, 1)});
    end

    // reverse fill (R4, R5)
    @(negedge clk);
    dir_fwd = 1'b0;
    #1;
    chk("R5 reverse enables", {60'd0, a0_oe, b0_oe, a1_oe, b1_oe}, 64'b1010);
    for (int k = 0; k < 2 * N; k++) step(1'b0, pat(k, 4));
    chk("R4 first bit on head after 128 edges", {63'd0, a0_o}, {63'd0, pat(0, 4)});
    latch_now();
    for (int n = 1; n <= N; n++) begin
      e0[n-1] = pat(n - 1, 4);
      e1[n-1] = pat(N - 1 + n, 4);
    end
    chk("R4 reverse stages first driver", drv0, e0);
    chk("R4 reverse stages second driver", drv1, e1);

    // full blank / polarity table on the held latch (R8, R9)
    for (int bl = 0; bl < 2; bl++) begin
      for (int po = 0; po < 2; po++) begin
        blank = bl[0];
        polarity = po[0];
        #1;
        chk(bl[0] ? "R8 blank row" : "R9 data row", drv0,
            bl[0] ? {N{po[0]}} : (e0 ^ {N{po[0]}}));
      end
    end
    strobe = 1'b1;
    blank = 1'b1;
    polarity = 1'b0;
    #1;
    chk("R8 blank with strobe high", drv0, '0);
    strobe = 1'b0;
    blank = 1'b0;
    #1;

    // latch hold while register shifts (R7)
    step(1'b0, 1'b1);
    chk("R7 latch holds with strobe low", drv0, e0);
    @(negedge clk);
    clk_en = 1'b0;
    strobe = 1'b1;
    #1;
    for (int n = 1; n <= N; n++) e0[n-1] = pat(n, 4);
    chk("R7 latch follows with strobe high", drv0, e0);

    // no edge: serial input wiggles, transparent latch shows no change (R6)
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      tail_in = ~tail_in;
      head_in = ~head_in;
    end
    #2;
    chk("R6 hold without clock edge", drv0, e0);
    strobe = 1'b0;

    // asynchronous reset mid-run (R1)
    #1;
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears", drv0 | drv1, '0);
    chk("R1 reset serial out reverse", {63'd0, a0_o}, '0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule